// File: doc/BRIEF.md
# Constrained King Tour Tracker

This block follows a king walking on a square grid, five cells on a side by default. It takes at most one step per clock. The grid position, the set of cells already entered and a use count for each of the eight compass directions live in registers. A requester drives a direction code together with a valid strobe. The block reports at once, combinationally, whether that step would be legal. On the next clock edge it either applies the step or rejects it and raises a one-cycle rejection pulse.

Every direction has a fixed lifetime allowance of three uses, so a full route has at most 24 accepted steps. Three status outputs are derived from the registered state:
- one flag says every cell has been entered;
- one flag says every cell other than the middle one has been entered, whatever the state of the middle cell;
- a pruning indicator says that more cells remain unentered than there are steps left in the allowance.

A search engine or stimulus generator chooses the route. This block only applies steps and evaluates these conditions. The starting cell comes from two inputs that are sampled while reset is held.

Top module: `king_tour_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge loads the position from `start_row`/`start_col`, clears every direction count, sets `moves_left` to the full allowance (8 × MAX_USES), clears `illegal_move` and leaves only the start cell marked in `visited_map`. The start cell must be on the board; it is normally not the middle cell.
- R2: Row 0 is the north edge and column 0 is the west edge. Direction codes are 0=N (row−1), 1=NE (row−1, col+1), 2=E (col+1), 3=SE (row+1, col+1), 4=S (row+1), 5=SW (row+1, col−1), 6=W (col−1) and 7=NW (row−1, col−1). A legal requested step moves `cur_row`/`cur_col` at the next clock edge.
- R3: `move_legal` is low when the requested step would leave the board. A rejected request changes no position, count or visited bit.
- R4: `dir_uses` holds one count of width clog2(MAX_USES+1) per direction, with direction d at bits [d*W +: W]. A direction whose count equals MAX_USES is not legal, so a count never exceeds MAX_USES.
- R5: `illegal_move` is high for exactly the one cycle after a clock edge that saw `move_valid` high with `move_legal` low. It is low after every other edge.
- R6: `visited_map` bit row*BOARD_N+col is set when the king enters that cell. Bits are never cleared except by reset.
- R7: `moves_left` equals the full allowance minus the number of accepted steps since reset. A step onto a cell already entered still counts.
- R8: `all_visited` is high exactly when every bit of `visited_map` is set.
- R9: `all_but_centre` is high exactly when every bit other than the middle cell's (index (N/2)*N+N/2) is set. The middle bit has no effect on it.
- R10: `prune_flag` is high exactly when the number of clear bits in `visited_map` is greater than `moves_left`.
- R11: When `move_valid` is low, position, counts, visited map and `moves_left` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the start cell |
| start_row | input | COORD_W | Start row, sampled during reset |
| start_col | input | COORD_W | Start column, sampled during reset |
| move_valid | input | 1 | A step is requested this cycle |
| move_dir | input | 3 | Requested direction code (R2) |
| move_legal | output | 1 | Requested step stays on the board and its direction has allowance left |
| illegal_move | output | 1 | One-cycle pulse after a rejected request |
| cur_row | output | COORD_W | Current row |
| cur_col | output | COORD_W | Current column |
| visited_map | output | BOARD_N*BOARD_N | One bit per cell, row-major |
| dir_uses | output | 8*CNT_W | Per-direction use counts |
| moves_left | output | LEFT_W | Steps still available in the allowance |
| all_visited | output | 1 | Every cell entered |
| all_but_centre | output | 1 | Every cell except the middle one entered |
| prune_flag | output | 1 | Unentered cells outnumber remaining steps |

## Verification
The bench builds two instances. The first uses the default parameters (a 5×5 board and three uses per direction). It carries the boundary, saturation, rejection and pruning checks, and the random walks from many start cells. With three uses per direction a full tour is hard or impossible to reach by simple stimulus. The second instance therefore keeps the 5×5 board but raises the allowance to nine uses per direction, which widens every count to four bits and the remaining-step output to seven. That makes a plain back-and-forth route possible: it enters every outer and inner cell first and the middle cell last. Both completion flags can then be seen switching in their correct order.

// File: rtl/king_pkg.sv
package king_pkg;

    localparam int NUM_DIRS = 8;

    typedef enum logic [2:0] {
        DIR_N  = 3'd0,
        DIR_NE = 3'd1,
        DIR_E  = 3'd2,
        DIR_SE = 3'd3,
        DIR_S  = 3'd4,
        DIR_SW = 3'd5,
        DIR_W  = 3'd6,
        DIR_NW = 3'd7
    } dir_e;

    // Row offset of one step; row 0 is the north edge.
    function automatic logic signed [1:0] row_delta(dir_e d);
        case (d)
            DIR_N, DIR_NE, DIR_NW: return -2'sd1;
            DIR_S, DIR_SE, DIR_SW: return 2'sd1;
            default:               return 2'sd0;
        endcase
    endfunction

    // Column offset of one step; column 0 is the west edge.
    function automatic logic signed [1:0] col_delta(dir_e d);
        case (d)
            DIR_E, DIR_NE, DIR_SE: return 2'sd1;
            DIR_W, DIR_NW, DIR_SW: return -2'sd1;
            default:               return 2'sd0;
        endcase
    endfunction

endpackage

// File: rtl/king_step.sv
module king_step
    import king_pkg::*;
#(
    parameter int BOARD_N = 5,
    localparam int COORD_W = $clog2(BOARD_N)
) (
    input  logic [COORD_W-1:0] cur_row,
    input  logic [COORD_W-1:0] cur_col,
    input  logic [2:0]         dir,
    output logic [COORD_W-1:0] tgt_row,
    output logic [COORD_W-1:0] tgt_col,
    output logic               on_board
);

    int r_i;
    int c_i;

    always_comb begin
        r_i      = int'(cur_row) + int'(row_delta(dir_e'(dir)));
        c_i      = int'(cur_col) + int'(col_delta(dir_e'(dir)));
        on_board = (r_i >= 0) && (r_i < BOARD_N) && (c_i >= 0) && (c_i < BOARD_N);
        tgt_row  = COORD_W'(r_i);
        tgt_col  = COORD_W'(c_i);
    end

endmodule

// File: rtl/king_dir_budget.sv
module king_dir_budget
    import king_pkg::*;
#(
    parameter int MAX_USES = 3,
    localparam int CNT_W = $clog2(MAX_USES + 1)
) (
    input  logic [NUM_DIRS*CNT_W-1:0] uses_in,
    input  logic [2:0]                dir,
    input  logic                      bump,
    output logic                      exhausted,
    output logic [NUM_DIRS*CNT_W-1:0] uses_out
);

    logic [NUM_DIRS-1:0] full;

    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
        logic [CNT_W-1:0] cnt;
        logic             hit;
        assign cnt     = uses_in[g*CNT_W +: CNT_W];
        assign hit     = bump && (dir == 3'(g));
        assign full[g] = (cnt == CNT_W'(MAX_USES));
        assign uses_out[g*CNT_W +: CNT_W] = hit ? cnt + CNT_W'(1) : cnt;
    end

    assign exhausted = full[dir];

endmodule

// File: rtl/king_board_eval.sv
module king_board_eval #(
    parameter int BOARD_N = 5,
    parameter int LEFT_W  = 5,
    localparam int CELLS      = BOARD_N * BOARD_N,
    localparam int CENTRE_IDX = (BOARD_N / 2) * BOARD_N + (BOARD_N / 2),
    localparam int UNV_W      = $clog2(CELLS + 1)
) (
    input  logic [CELLS-1:0]  visited,
    input  logic [LEFT_W-1:0] moves_left,
    output logic              all_visited,
    output logic              all_but_centre,
    output logic              prune
);

    localparam logic [CELLS-1:0] CENTRE_MASK = CELLS'(1) << CENTRE_IDX;

    logic [UNV_W-1:0] unvisited;

    always_comb begin
        unvisited = '0;
        for (int i = 0; i < CELLS; i++) begin
            unvisited = unvisited + UNV_W'(!visited[i]);
        end
        all_visited    = &visited;
        all_but_centre = &(visited | CENTRE_MASK);
        prune          = int'(unvisited) > int'(moves_left);
    end

endmodule

// File: rtl/king_tour_tracker.sv
module king_tour_tracker
    import king_pkg::*;
#(
    parameter int BOARD_N  = 5,
    parameter int MAX_USES = 3,
    localparam int COORD_W = $clog2(BOARD_N),
    localparam int CELLS   = BOARD_N * BOARD_N,
    localparam int CNT_W   = $clog2(MAX_USES + 1),
    localparam int BUDGET  = NUM_DIRS * MAX_USES,
    localparam int LEFT_W  = $clog2(BUDGET + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [COORD_W-1:0]        start_row,
    input  logic [COORD_W-1:0]        start_col,
    input  logic                      move_valid,
    input  logic [2:0]                move_dir,
    output logic                      move_legal,
    output logic                      illegal_move,
    output logic [COORD_W-1:0]        cur_row,
    output logic [COORD_W-1:0]        cur_col,
    output logic [CELLS-1:0]          visited_map,
    output logic [NUM_DIRS*CNT_W-1:0] dir_uses,
    output logic [LEFT_W-1:0]         moves_left,
    output logic                      all_visited,
    output logic                      all_but_centre,
    output logic                      prune_flag
);

    localparam int IDX_W = $clog2(CELLS);

    typedef struct packed {
        logic [COORD_W-1:0]        row;
        logic [COORD_W-1:0]        col;
        logic [CELLS-1:0]          vis;
        logic [NUM_DIRS*CNT_W-1:0] uses;
        logic [LEFT_W-1:0]         taken;
        logic                      ill;
    } state_t;

    state_t st_q, st_d;

    logic [COORD_W-1:0]        tgt_row, tgt_col;
    logic                      on_board, exhausted, accept;
    logic [NUM_DIRS*CNT_W-1:0] uses_nxt;
    logic [IDX_W-1:0]          tgt_idx, start_idx;

    king_step #(.BOARD_N(BOARD_N)) u_step (
        .cur_row  (st_q.row),
        .cur_col  (st_q.col),
        .dir      (move_dir),
        .tgt_row  (tgt_row),
        .tgt_col  (tgt_col),
        .on_board (on_board)
    );

    king_dir_budget #(.MAX_USES(MAX_USES)) u_budget (
        .uses_in   (st_q.uses),
        .dir       (move_dir),
        .bump      (accept),
        .exhausted (exhausted),
        .uses_out  (uses_nxt)
    );

    assign move_legal = on_board && !exhausted;
    assign accept     = move_valid && move_legal;
    assign tgt_idx    = IDX_W'(int'(tgt_row) * BOARD_N + int'(tgt_col));
    assign start_idx  = IDX_W'(int'(start_row) * BOARD_N + int'(start_col));

    always_comb begin
        st_d     = st_q;
        st_d.ill = move_valid && !move_legal;
        if (!rst_n) begin
            st_d.row   = start_row;
            st_d.col   = start_col;
            st_d.vis   = CELLS'(1) << start_idx;
            st_d.uses  = '0;
            st_d.taken = '0;
            st_d.ill   = 1'b0;
        end else if (accept) begin
            st_d.row   = tgt_row;
            st_d.col   = tgt_col;
            st_d.vis   = st_q.vis | (CELLS'(1) << tgt_idx);
            st_d.uses  = uses_nxt;
            st_d.taken = st_q.taken + LEFT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cur_row      = st_q.row;
    assign cur_col      = st_q.col;
    assign visited_map  = st_q.vis;
    assign dir_uses     = st_q.uses;
    assign illegal_move = st_q.ill;
    assign moves_left   = LEFT_W'(BUDGET) - st_q.taken;

    king_board_eval #(.BOARD_N(BOARD_N), .LEFT_W(LEFT_W)) u_eval (
        .visited        (st_q.vis),
        .moves_left     (moves_left),
        .all_visited    (all_visited),
        .all_but_centre (all_but_centre),
        .prune          (prune_flag)
    );

endmodule

// File: rtl/king_tour_tracker_chk.sv
module king_tour_tracker_chk
    import king_pkg::*;
#(
    parameter int BOARD_N  = 5,
    parameter int MAX_USES = 3,
    localparam int COORD_W = $clog2(BOARD_N),
    localparam int CELLS   = BOARD_N * BOARD_N,
    localparam int CNT_W   = $clog2(MAX_USES + 1),
    localparam int BUDGET  = NUM_DIRS * MAX_USES,
    localparam int LEFT_W  = $clog2(BUDGET + 1)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      move_valid,
    input logic                      move_legal,
    input logic                      illegal_move,
    input logic [COORD_W-1:0]        cur_row,
    input logic [COORD_W-1:0]        cur_col,
    input logic [CELLS-1:0]          visited_map,
    input logic [NUM_DIRS*CNT_W-1:0] dir_uses,
    input logic [LEFT_W-1:0]         moves_left,
    input logic                      all_visited,
    input logic                      all_but_centre
);

    AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (move_valid && !move_legal) |=> illegal_move); // R5

    AST_NO_SPURIOUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!move_valid || move_legal) |=> !illegal_move); // R5

    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (move_valid && !move_legal) |=>
            ($stable(cur_row) && $stable(cur_col) && $stable(visited_map) && $stable(dir_uses))); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !move_valid |=>
            ($stable(cur_row) && $stable(cur_col) && $stable(visited_map) && $stable(moves_left))); // R11

    AST_MAP_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (move_valid && move_legal) |=>
            ((visited_map & $past(visited_map)) == $past(visited_map))); // R6

    AST_STEP_SPENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (move_valid && move_legal) |=> (moves_left == $past(moves_left) - LEFT_W'(1))); // R7

    AST_FULL_IMPLIES_RING: assert property (@(posedge clk) disable iff (!rst_n)
        all_visited |-> all_but_centre); // R9

    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_cnt
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            dir_uses[g*CNT_W +: CNT_W] <= CNT_W'(MAX_USES)); // R4
    end

endmodule

bind king_tour_tracker king_tour_tracker_chk #(.BOARD_N(BOARD_N), .MAX_USES(MAX_USES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .move_valid     (move_valid),
    .move_legal     (move_legal),
    .illegal_move   (illegal_move),
    .cur_row        (cur_row),
    .cur_col        (cur_col),
    .visited_map    (visited_map),
    .dir_uses       (dir_uses),
    .moves_left     (moves_left),
    .all_visited    (all_visited),
    .all_but_centre (all_but_centre)
);

// File: tb/king_tour_tracker_tb_top.sv
module king_tour_tracker_tb_top;

    localparam int N   = 5;
    localparam int U   = 3;
    localparam int CW  = 2;
    localparam int LW  = 5;
    localparam int TU  = 9;
    localparam int TCW = 4;
    localparam int TLW = 7;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n = 1'b0;
    logic [2:0]   s_row = 3'd0, s_col = 3'd0;
    logic         valid = 1'b0;
    logic [2:0]   dir   = 3'd0;
    logic         legal, ill, all_v, ring, prune;
    logic [2:0]   row, col;
    logic [24:0]  vis;
    logic [8*CW-1:0] uses;
    logic [LW-1:0] left;

    logic         t_valid = 1'b0;
    logic [2:0]   t_dir   = 3'd0;
    logic         t_legal, t_ill, t_all_v, t_ring, t_prune;
    logic [2:0]   t_row, t_col;
    logic [24:0]  t_vis;
    logic [8*TCW-1:0] t_uses;
    logic [TLW-1:0] t_left;

    king_tour_tracker #(.BOARD_N(N), .MAX_USES(U)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_row(s_row), .start_col(s_col),
        .move_valid(valid), .move_dir(dir), .move_legal(legal), .illegal_move(ill),
        .cur_row(row), .cur_col(col), .visited_map(vis), .dir_uses(uses),
        .moves_left(left), .all_visited(all_v), .all_but_centre(ring), .prune_flag(prune)
    );

    king_tour_tracker #(.BOARD_N(N), .MAX_USES(TU)) tour_i (
        .clk(clk), .rst_n(rst_n), .start_row(3'd0), .start_col(3'd0),
        .move_valid(t_valid), .move_dir(t_dir), .move_legal(t_legal), .illegal_move(t_ill),
        .cur_row(t_row), .cur_col(t_col), .visited_map(t_vis), .dir_uses(t_uses),
        .moves_left(t_left), .all_visited(t_all_v), .all_but_centre(t_ring), .prune_flag(t_prune)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model for dut_i
    int m_row, m_col, m_taken;
    int m_uses[8];
    bit [24:0] m_vis;
    bit m_ill;

    function automatic int dr(int d);
        if (d == 0 || d == 1 || d == 7) return -1;
        if (d == 3 || d == 4 || d == 5) return 1;
        return 0;
    endfunction

    function automatic int dc(int d);
        if (d == 1 || d == 2 || d == 3) return 1;
        if (d == 5 || d == 6 || d == 7) return -1;
        return 0;
    endfunction

    function automatic bit model_legal(int d);
        int nr = m_row + dr(d);
        int nc = m_col + dc(d);
        return nr >= 0 && nr < N && nc >= 0 && nc < N && m_uses[d] < U;
    endfunction

    function automatic int model_unvisited();
        int z = 0;
        for (int i = 0; i < 25; i++) if (!m_vis[i]) z++;
        return z;
    endfunction

    task automatic model_reset(int r, int c);
        m_row = r; m_col = c; m_taken = 0; m_ill = 0;
        for (int d = 0; d < 8; d++) m_uses[d] = 0;
        m_vis = '0;
        m_vis[r*N + c] = 1'b1;
    endtask

    task automatic compare_all();
        int unv = model_unvisited();
        int lft = 8*U - m_taken;
        chk("R2 row", int'(row), m_row);
        chk("R2 col", int'(col), m_col);
        chk("R6 visited_map", int'(vis), int'(m_vis));
        for (int d = 0; d < 8; d++) chk("R4 dir_uses", int'(uses[d*CW +: CW]), m_uses[d]);
        chk("R7 moves_left", int'(left), lft);
        chk("R5 illegal_move", int'(ill), int'(m_ill));
        chk("R8 all_visited", int'(all_v), int'(m_vis == 25'h1FF_FFFF));
        chk("R9 all_but_centre", int'(ring), int'((m_vis | 25'h000_1000) == 25'h1FF_FFFF));
        chk("R10 prune_flag", int'(prune), int'(unv > lft));
    endtask

    // Called at a negedge; returns at the next negedge after comparing.
    task automatic step(bit v, int d);
        bit lg;
        valid = v;
        dir   = 3'(d);
        #1;
        lg = model_legal(d);
        chk("R3 move_legal", int'(legal), int'(lg));
        m_ill = v && !lg;
        if (v && lg) begin
            m_row += dr(d);
            m_col += dc(d);
            m_uses[d]++;
            m_taken++;
            m_vis[m_row*N + m_col] = 1'b1;
        end
        @(negedge clk);
        valid = 1'b0;
        compare_all();
    endtask

    task automatic do_reset(int r, int c);
        rst_n = 1'b0;
        valid = 1'b0;
        s_row = 3'(r);
        s_col = 3'(c);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset(r, c);
        compare_all();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset(0, 0);
        // R1: reset state at corner start
        chk("R1 row", int'(row), 0);
        chk("R1 col", int'(col), 0);
        chk("R1 visited_map", int'(vis), 1);
        chk("R1 dir_uses", int'(uses), 0);
        chk("R1 moves_left", int'(left), 24);
        chk("R1 illegal_move", int'(ill), 0);
        compare_all();

        // R3: north from the north edge leaves the board
        step(1'b1, 0);
        chk("R3 row held", int'(row), 0);
        chk("R5 pulse after reject", int'(ill), 1);
        // R11 and end of R5 pulse
        step(1'b0, 2);
        chk("R5 pulse ends", int'(ill), 0);
        chk("R11 col held while idle", int'(col), 0);
        chk("R11 moves_left held", int'(left), 24);

        // R4: three east steps then the fourth is refused
        step(1'b1, 2);
        step(1'b1, 2);
        step(1'b1, 2);
        chk("R2 col after three east", int'(col), 3);
        step(1'b1, 2);
        chk("R4 fourth east refused", int'(col), 3);
        chk("R4 east count saturated", int'(uses[2*CW +: CW]), 3);
        chk("R4 reject pulse", int'(ill), 1);

        // R10: revisit raises prune (21 unvisited > 20 left)
        step(1'b1, 6);
        chk("R10 prune after revisit", int'(prune), 1);
        chk("R7 revisit still counts", int'(left), 20);

        // Diagonal directed checks: SE then SW
        step(1'b1, 3);
        chk("R2 SE row", int'(row), 1);
        chk("R2 SE col", int'(col), 3);
        step(1'b1, 5);
        chk("R6 SW cell marked", int'(vis[2*N + 2]), 1);

        // Constrained random walks from random non-centre starts
        for (int ep = 0; ep < 60; ep++) begin
            int r, c;
            do begin
                r = int'($urandom % 5);
                c = int'($urandom % 5);
            end while (r == 2 && c == 2);
            do_reset(r, c);
            for (int k = 0; k < 40; k++) begin
                step(($urandom % 4) != 0, int'($urandom % 8));
            end
        end

        // Completion flags on the widened-allowance instance
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 tour moves_left", int'(t_left), 72);
        begin
            int route[24] = '{2,2,2,2, 4, 6,6,6,6, 4,4,4, 2,2,2,2, 0,0, 6, 4, 6,6, 0, 2};
            for (int i = 0; i < 24; i++) begin
                t_valid = 1'b1;
                t_dir   = 3'(route[i]);
                #1;
                chk("R2 tour step legal", int'(t_legal), 1);
                @(negedge clk);
                t_valid = 1'b0;
                if (i == 21) chk("R9 ring not yet complete", int'(t_ring), 0);
                if (i == 22) begin
                    chk("R9 ring complete, centre clear", int'(t_ring), 1);
                    chk("R8 full not yet", int'(t_all_v), 0);
                    chk("R6 centre clear", int'(t_vis[12]), 0);
                end
            end
        end
        chk("R8 full after centre", int'(t_all_v), 1);
        chk("R9 ring with centre set", int'(t_ring), 1);
        chk("R7 tour moves_left", int'(t_left), 48);
        chk("R2 tour end row", int'(t_row), 2);
        chk("R2 tour end col", int'(t_col), 2);
        chk("R10 tour no prune", int'(t_prune), 0);
        chk("R5 tour no pulse", int'(t_ill), 0);
        finish_run();
    end

endmodule